// File: doc/BRIEF.md
# Tagged Wide Mailbox

This block carries one 128-bit message from a producer to a consumer. The message sits in four 32-bit data words. A separate tag word says whether the message is ready. The producer fills the data words and then writes the tag with its top bit set, which commits the message. The consumer reads the words and then writes zero to every data word and to the tag, which returns the box to empty. The flag that marks the box full is never part of the payload.

The producer and the consumer each have a write port on a small 32-bit register bus. Both share one combinational read port. Two level outputs, `full` and `empty`, follow the tag's top bit and feed an interrupt aggregator outside this block. While a message is committed, the producer cannot overwrite the data words. The consumer can always write.

Top module: `tagged_mbox`

## Requirements
- R1: After reset all four data words and the tag read as zero, `full` is 0 and `empty` is 1.
- R2: The tag is at byte offset 0x40. Data word k is at 0x48 + 4*k (0x48, 0x4C, 0x50, 0x54). A read of any other address returns zero, and a write to one changes nothing.
- R3: While the box is empty, a producer write to a data word stores its value, and that value reads back in the next cycle.
- R4: A tag write with bit 31 set makes `full` 1 and `empty` 0 from the next cycle. Only bit 31 decides fullness, and all 32 tag bits read back as written.
- R5: While `full` is 1, producer writes to data words are ignored.
- R6: Consumer writes to data words take effect whether the box is full or empty.
- R7: A tag write with bit 31 clear makes `empty` 1 and `full` 0 from the next cycle.
- R8: Reads of data words return the stored values in both the full and the empty state.
- R9: When the producer and the consumer write the same register in the same cycle, the consumer's value is stored.
- R10: `full` and `empty` are always complements of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prod_wr | input | 1 | Producer write strobe |
| prod_addr | input | 8 | Producer byte address |
| prod_wdata | input | 32 | Producer write data |
| cons_wr | input | 1 | Consumer write strobe |
| cons_addr | input | 8 | Consumer byte address |
| cons_wdata | input | 32 | Consumer write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data, combinational |
| full | output | 1 | Message committed (tag bit 31) |
| empty | output | 1 | No message committed |

## Verification
The bench tries to overwrite a committed word. A design without the full lock would return the intruding value instead of the committed one. It checks that the consumer's zero writes land while the box is still full. A design that locked both ports would leave stale data after the tag is cleared. Same-cycle writes by both ports to one data word and to the tag expose a design that lets the producer win. It would end up full when it should be empty. Tag values with only bit 31 clear, or only bit 31 set, expose a design that decides fullness from the whole word, and an unmapped address between the tag and the data words must read as zero.

// File: rtl/tmbx_pkg.sv
package tmbx_pkg;
   // byte address of data word k, given the base of the data block
   function automatic int word_addr(input int base, input int k);
      return base + 4 * k;
   endfunction

   // source that wins a same-cycle write to one register
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_PROD = 2'd1,
      SRC_CONS = 2'd2
   } wr_src_e;
endpackage

// File: rtl/tmbx_decode.sv
module tmbx_decode #(
   parameter int ADDR_W   = 8,
   parameter int N_WORDS  = 4,
   parameter int TAG_OFS  = 'h40,
   parameter int DATA_OFS = 'h48
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic               tag_hit,
   output logic [N_WORDS-1:0] word_hit
);
   import tmbx_pkg::*;

   assign tag_hit = (addr == ADDR_W'(TAG_OFS));

   for (genvar g = 0; g < N_WORDS; g++) begin : g_word
      assign word_hit[g] = (addr == ADDR_W'(word_addr(DATA_OFS, g)));
   end
endmodule

// File: rtl/tmbx_words.sv
module tmbx_words #(
   parameter int DATA_W  = 32,
   parameter int N_WORDS = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            locked,
   input  logic                            prod_wr,
   input  logic [N_WORDS-1:0]              prod_hit,
   input  logic [DATA_W-1:0]               prod_wdata,
   input  logic                            cons_wr,
   input  logic [N_WORDS-1:0]              cons_hit,
   input  logic [DATA_W-1:0]               cons_wdata,
   output logic [N_WORDS-1:0][DATA_W-1:0]  word_q
);
   import tmbx_pkg::*;

   for (genvar g = 0; g < N_WORDS; g++) begin : g_word
      wr_src_e src;

      always_comb begin
         if (cons_wr && cons_hit[g])
            src = SRC_CONS;
         else if (prod_wr && prod_hit[g] && !locked)
            src = SRC_PROD;
         else
            src = SRC_NONE;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q[g] <= '0;
         else if (src == SRC_CONS)
            word_q[g] <= cons_wdata;
         else if (src == SRC_PROD)
            word_q[g] <= prod_wdata;
      end
   end
endmodule

// File: rtl/tmbx_tag.sv
module tmbx_tag #(
   parameter int DATA_W   = 32,
   parameter int FLAG_BIT = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prod_wr,
   input  logic              prod_hit,
   input  logic [DATA_W-1:0] prod_wdata,
   input  logic              cons_wr,
   input  logic              cons_hit,
   input  logic [DATA_W-1:0] cons_wdata,
   output logic [DATA_W-1:0] tag_q,
   output logic              committed
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tag_q <= '0;
      else if (cons_wr && cons_hit)
         tag_q <= cons_wdata;
      else if (prod_wr && prod_hit)
         tag_q <= prod_wdata;
   end

   assign committed = tag_q[FLAG_BIT];
endmodule

// File: rtl/tagged_mbox.sv
module tagged_mbox #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int N_WORDS  = 4,
   parameter int TAG_OFS  = 'h40,
   parameter int DATA_OFS = 'h48,
   parameter int FLAG_BIT = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prod_wr,
   input  logic [ADDR_W-1:0] prod_addr,
   input  logic [DATA_W-1:0] prod_wdata,
   input  logic              cons_wr,
   input  logic [ADDR_W-1:0] cons_addr,
   input  logic [DATA_W-1:0] cons_wdata,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              full,
   output logic              empty
);
   localparam int LAST_OFS = DATA_OFS + 4 * (N_WORDS - 1);

   if (FLAG_BIT >= DATA_W) begin : g_bad_flag
      $error("FLAG_BIT must lie inside the data word");
   end
   if (N_WORDS < 1) begin : g_bad_words
      $error("N_WORDS must be at least one");
   end
   if (LAST_OFS >= (1 << ADDR_W)) begin : g_bad_span
      $error("data words do not fit the address space");
   end
   if (TAG_OFS >= DATA_OFS && TAG_OFS <= LAST_OFS) begin : g_bad_overlap
      $error("tag offset overlaps the data words");
   end

   logic                           p_tag_hit, c_tag_hit, r_tag_hit;
   logic [N_WORDS-1:0]             p_word_hit, c_word_hit, r_word_hit;
   logic [N_WORDS-1:0][DATA_W-1:0] word_q;
   logic [DATA_W-1:0]              tag_q;
   logic                           committed;

   tmbx_decode #(.ADDR_W(ADDR_W), .N_WORDS(N_WORDS), .TAG_OFS(TAG_OFS),
                 .DATA_OFS(DATA_OFS))
      u_dec_prod (.addr(prod_addr), .tag_hit(p_tag_hit), .word_hit(p_word_hit));

   tmbx_decode #(.ADDR_W(ADDR_W), .N_WORDS(N_WORDS), .TAG_OFS(TAG_OFS),
                 .DATA_OFS(DATA_OFS))
      u_dec_cons (.addr(cons_addr), .tag_hit(c_tag_hit), .word_hit(c_word_hit));

   tmbx_decode #(.ADDR_W(ADDR_W), .N_WORDS(N_WORDS), .TAG_OFS(TAG_OFS),
                 .DATA_OFS(DATA_OFS))
      u_dec_rd (.addr(rd_addr), .tag_hit(r_tag_hit), .word_hit(r_word_hit));

   tmbx_words #(.DATA_W(DATA_W), .N_WORDS(N_WORDS)) u_words (
      .clk        (clk),
      .rst_n      (rst_n),
      .locked     (committed),
      .prod_wr    (prod_wr),
      .prod_hit   (p_word_hit),
      .prod_wdata (prod_wdata),
      .cons_wr    (cons_wr),
      .cons_hit   (c_word_hit),
      .cons_wdata (cons_wdata),
      .word_q     (word_q)
   );

   tmbx_tag #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_tag (
      .clk        (clk),
      .rst_n      (rst_n),
      .prod_wr    (prod_wr),
      .prod_hit   (p_tag_hit),
      .prod_wdata (prod_wdata),
      .cons_wr    (cons_wr),
      .cons_hit   (c_tag_hit),
      .cons_wdata (cons_wdata),
      .tag_q      (tag_q),
      .committed  (committed)
   );

   always_comb begin
      rd_data = '0;
      if (r_tag_hit)
         rd_data = tag_q;
      for (int i = 0; i < N_WORDS; i++) begin
         if (r_word_hit[i])
            rd_data = word_q[i];
      end
   end

   assign full  = committed;
   assign empty = ~committed;
endmodule

// File: rtl/tmbx_chk.sv
module tmbx_chk #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int N_WORDS  = 4,
   parameter int TAG_OFS  = 'h40
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           prod_wr,
   input logic [ADDR_W-1:0]              prod_addr,
   input logic                           prod_set,
   input logic                           cons_wr,
   input logic [ADDR_W-1:0]              cons_addr,
   input logic [DATA_W-1:0]              cons_wdata,
   input logic                           cons_set,
   input logic                           full,
   input logic                           empty,
   input logic [DATA_W-1:0]              tag_q,
   input logic [N_WORDS-1:0][DATA_W-1:0] word_q
);
   logic p_tag_wr, c_tag_wr;
   assign p_tag_wr = prod_wr && (prod_addr == ADDR_W'(TAG_OFS));
   assign c_tag_wr = cons_wr && (cons_addr == ADDR_W'(TAG_OFS));

   // R10: level outputs stay complementary
   p_complement_r10: assert property (@(posedge clk) disable iff (!rst_n)
      full != empty);

   // R4: producer commit raises full in the next cycle
   p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (p_tag_wr && prod_set && !c_tag_wr) |=> full);

   // R7: consumer tag clear raises empty in the next cycle
   p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (c_tag_wr && !cons_set) |=> empty);

   // R5: committed data words only change through the consumer
   p_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !cons_wr) |=> $stable(word_q));

   // R9: consumer wins a same-cycle tag write
   p_cons_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (c_tag_wr && p_tag_wr) |=> (tag_q == $past(cons_wdata)));
endmodule

bind tagged_mbox tmbx_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_WORDS(N_WORDS), .TAG_OFS(TAG_OFS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .prod_wr    (prod_wr),
   .prod_addr  (prod_addr),
   .prod_set   (prod_wdata[FLAG_BIT]),
   .cons_wr    (cons_wr),
   .cons_addr  (cons_addr),
   .cons_wdata (cons_wdata),
   .cons_set   (cons_wdata[FLAG_BIT]),
   .full       (full),
   .empty      (empty),
   .tag_q      (tag_q),
   .word_q     (word_q)
);

// File: tb/tagged_mbox_bench.sv
module tagged_mbox_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NV    = 18;
   localparam int VEC_W = 4 + 1 + 8 + 32 + 1 + 8 + 32 + 8 + 32 + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prod_wr = 1'b0;
   logic [7:0]  prod_addr = '0;
   logic [31:0] prod_wdata = '0;
   logic        cons_wr = 1'b0;
   logic [7:0]  cons_addr = '0;
   logic [31:0] cons_wdata = '0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        full, empty;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   tagged_mbox u_tagged_mbox (
      .clk(clk), .rst_n(rst_n),
      .prod_wr(prod_wr), .prod_addr(prod_addr), .prod_wdata(prod_wdata),
      .cons_wr(cons_wr), .cons_addr(cons_addr), .cons_wdata(cons_wdata),
      .rd_addr(rd_addr), .rd_data(rd_data), .full(full), .empty(empty)
   );

   // {req, pwr, paddr, pdata, cwr, caddr, cdata, raddr, exp_rdata, exp_full}
   localparam logic [VEC_W-1:0] VECS [NV] = '{
      {4'd3, 1'b1, 8'h48, 32'h11111111, 1'b0, 8'h00, 32'h0, 8'h48, 32'h11111111, 1'b0}, // R3
      {4'd3, 1'b1, 8'h4C, 32'h22222222, 1'b0, 8'h00, 32'h0, 8'h4C, 32'h22222222, 1'b0}, // R3
      {4'd3, 1'b1, 8'h50, 32'h33333333, 1'b0, 8'h00, 32'h0, 8'h48, 32'h11111111, 1'b0}, // R3
      {4'd3, 1'b1, 8'h54, 32'h44444444, 1'b0, 8'h00, 32'h0, 8'h54, 32'h44444444, 1'b0}, // R3
      {4'd4, 1'b1, 8'h40, 32'h80000005, 1'b0, 8'h00, 32'h0, 8'h40, 32'h80000005, 1'b1}, // R4
      {4'd5, 1'b1, 8'h48, 32'hDEADBEEF, 1'b0, 8'h00, 32'h0, 8'h48, 32'h11111111, 1'b1}, // R5
      {4'd8, 1'b0, 8'h00, 32'h0,        1'b0, 8'h00, 32'h0, 8'h50, 32'h33333333, 1'b1}, // R8
      {4'd2, 1'b1, 8'h44, 32'hFFFFFFFF, 1'b0, 8'h00, 32'h0, 8'h44, 32'h00000000, 1'b1}, // R2
      {4'd6, 1'b0, 8'h00, 32'h0,        1'b1, 8'h48, 32'h0, 8'h48, 32'h00000000, 1'b1}, // R6
      {4'd6, 1'b0, 8'h00, 32'h0,        1'b1, 8'h4C, 32'h0, 8'h4C, 32'h00000000, 1'b1}, // R6
      {4'd6, 1'b0, 8'h00, 32'h0,        1'b1, 8'h50, 32'h0, 8'h50, 32'h00000000, 1'b1}, // R6
      {4'd6, 1'b0, 8'h00, 32'h0,        1'b1, 8'h54, 32'h0, 8'h54, 32'h00000000, 1'b1}, // R6
      {4'd7, 1'b0, 8'h00, 32'h0,        1'b1, 8'h40, 32'h0, 8'h40, 32'h00000000, 1'b0}, // R7
      {4'd3, 1'b1, 8'h48, 32'hAAAA5555, 1'b0, 8'h00, 32'h0, 8'h48, 32'hAAAA5555, 1'b0}, // R3
      {4'd9, 1'b1, 8'h4C, 32'h12345678, 1'b1, 8'h4C, 32'h0BADF00D, 8'h4C, 32'h0BADF00D, 1'b0}, // R9
      {4'd9, 1'b1, 8'h40, 32'h80000000, 1'b1, 8'h40, 32'h0, 8'h40, 32'h00000000, 1'b0}, // R9
      {4'd4, 1'b1, 8'h40, 32'h7FFFFFFF, 1'b0, 8'h00, 32'h0, 8'h40, 32'h7FFFFFFF, 1'b0}, // R4
      {4'd4, 1'b1, 8'h40, 32'hFFFFFFFF, 1'b0, 8'h00, 32'h0, 8'h40, 32'hFFFFFFFF, 1'b1}  // R4
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // R1 R2: all five registers read as zero and the box reads empty
   task automatic check_cleared(input string req);
      rd_addr = 8'h40;
      #1 check(rd_data == 32'h0, req, rd_data, 32'h0);
      for (int k = 0; k < 4; k++) begin
         rd_addr = 8'(8'h48 + 4 * k);
         #1 check(rd_data == 32'h0, req, rd_data, 32'h0);
      end
      check(full == 1'b0 && empty == 1'b1, req, {30'h0, full, empty}, 32'h1);
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check_cleared("R1");
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         logic [VEC_W-1:0] w;
         logic [3:0]  req;
         logic [31:0] exp_d;
         logic        exp_f;
         w = VECS[v];
         {req, prod_wr, prod_addr, prod_wdata, cons_wr, cons_addr, cons_wdata,
          rd_addr, exp_d, exp_f} = w;
         @(negedge clk);
         prod_wr = 1'b0;
         cons_wr = 1'b0;
         #1;
         check(rd_data == exp_d, $sformatf("R%0d data v%0d", req, v), rd_data, exp_d);
         check(full == exp_f, $sformatf("R%0d full v%0d", req, v),
               {31'h0, full}, {31'h0, exp_f});
         // R10: empty is the complement of full
         check(empty == !full, "R10", {31'h0, empty}, {31'h0, !full});
      end

      // R1: reset in the middle of a committed message clears everything
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_cleared("R1 midrun");
      rst_n = 1'b1;
      @(negedge clk);

      // R2: write to an address past the data words changes nothing
      prod_wr = 1'b1; prod_addr = 8'h58; prod_wdata = 32'h5A5A5A5A;
      @(negedge clk);
      prod_wr = 1'b0;
      check_cleared("R2");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule